// File: doc/BRIEF.md
# Transmit Link Control and Status Register File

This block is the software-facing control and status register file for a serial transmit link. A processor reaches it over an AXI4-Lite slave port. Through that port, software reads the identity constants, keeps a scratch word, and turns the link on and off. It can also watch the link's status, load the link and alignment-sequence configuration, and ask for a one-shot manual synchronization. The configuration fields, a link-enable level and a single-cycle manual sync strobe are driven straight out to the link logic. Everything runs on one clock.

An interrupt unit records event pulses arriving from the link. Each event sets a sticky source bit. A per-bit enable mask controls only whether a recorded event is passed on: it is never a condition for recording. The enabled events form the pending set, and any pending bit raises `irq`. While the link is enabled, the configuration words are locked, so a running link never sees its parameters change.

Two small state machines form the bus front end. The write machine has the states WR_IDLE and WR_RESP. It moves from WR_IDLE to WR_RESP when address and data are both valid, and from WR_RESP back to WR_IDLE on `bready`. The read machine has the states RD_IDLE and RD_DATA. It moves from RD_IDLE to RD_DATA on `arvalid`, and back to RD_IDLE on `rready`.

Top module: `txlink_csr`

## Requirements
- R1: Byte address 0x000 reads the VERSION parameter and 0x004 reads the INST_ID parameter. Byte address 0x00C reads 0x32303454, the ASCII text "204T". Writes to these three addresses change nothing.
- R2: The scratch word at 0x008 resets to 0 and reads back what was written. Only the bytes whose `wstrb` bit is 1 are updated. This byte rule applies to every read/write register.
- R3: The link-disable register at 0x0C0 (bit 0) resets to 1. Writing 0 to it enables the link and writing 1 disables it. `link_en` is high when this bit is 0 and `ext_reset` is low, and it follows a write one cycle after the write is accepted.
- R4: The link status register at 0x0C4 has two bits. Bit 0 reads 1 while the link is disabled or `link_init` is high. Bit 1 reads the `ext_reset` input. While `ext_reset` is high, `link_en` stays low.
- R5: The configuration registers accept writes only while `link_en` is low. While `link_en` is high, writes to them are ignored. The registers are:
  - 0x200: lane disables, bit n for lane n, output on `cfg_lanes_off`.
  - 0x210: frame octets minus one in bits [7:0] (`cfg_frame_oct`) and multiframe octets minus one in bits [25:16] (`cfg_mf_oct`, reset value 31).
  - 0x214: scrambler off in bit 0 and character replacement off in bit 1.
  - 0x240: `cfg_mode`, with hold-CGS in bit 0, hold-ILAS in bit 1 and skip-ILAS in bit 2.
  - 0x250: the alignment-sequence word, output on `cfg_ilas_word`.
- R6: A high `irq_evt[i]` sets source bit i, which reads at 0x088. The bit is set whatever the state of its enable bit, and it stays set through any further events.
- R7: The enable mask is at 0x080. The pending register at 0x084 reads as source AND enable. `irq` is high whenever any pending bit is 1, so enabling an event that is already recorded raises `irq`.
- R8: Writing ones to 0x088 or to 0x084 clears the matching source bits, and several bits can be cleared in one write. Zero bits have no effect.
- R9: Writing bit 0 = 1 to 0x248 while `link_en` is high drives `sync_pulse` high for exactly one cycle. Writing 0, or writing while the link is disabled, produces no pulse. The address always reads 0.
- R10: Bits [1:0] of 0x280 read the `link_state` input.
- R11: Addresses that are not mapped read 0. Every response is OKAY (0). `bvalid` and `rvalid` each stay high until their ready signal is seen, and each channel holds one transaction at a time.
- R12: If an event and a write that clears the same source bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response (always OKAY) |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response (always OKAY) |
| irq_evt | input | NUM_IRQ | Interrupt event pulses |
| ext_reset | input | 1 | External link reset state |
| link_init | input | 1 | Link is initializing |
| link_state | input | 2 | Link state code |
| link_en | output | 1 | Link enable |
| sync_pulse | output | 1 | Manual sync strobe |
| irq | output | 1 | Interrupt request |
| cfg_lanes_off | output | NUM_LANES | Per-lane disable |
| cfg_frame_oct | output | 8 | Frame octets minus one |
| cfg_mf_oct | output | 10 | Multiframe octets minus one |
| cfg_scr_off | output | 1 | Scrambler off |
| cfg_repl_off | output | 1 | Character replacement off |
| cfg_mode | output | 3 | Hold-CGS, hold-ILAS, skip-ILAS |
| cfg_ilas_word | output | 32 | Alignment-sequence configuration word |

## Verification
The bench builds the block with NUM_LANES = 6, NUM_IRQ = 5, INST_ID = 0x15 and the default 12-bit address. Six lanes is not a power of two, so the top bits of the lane-disable word fall outside the port, and a write that sets them shows that they are dropped. Five event bits leave the upper bits of the source, enable and pending words unused, so clears of several bits at once and random masks cover both the live and the dead bits. A non-default instance ID shows that the parameter, not a constant, reaches address 0x004.

// File: rtl/txlink_csr_pkg.sv
package txlink_csr_pkg;

    localparam logic [31:0] IDENT_WORD = 32'h3230_3454;

    localparam int FR_W = 8;
    localparam int MF_W = 10;
    localparam int MODE_W = 3;

    localparam int ADR_VERSION  = 'h000;
    localparam int ADR_INST     = 'h004;
    localparam int ADR_SCRATCH  = 'h008;
    localparam int ADR_IDENT    = 'h00C;
    localparam int ADR_IRQ_EN   = 'h080;
    localparam int ADR_IRQ_PEND = 'h084;
    localparam int ADR_IRQ_SRC  = 'h088;
    localparam int ADR_LINK_OFF = 'h0C0;
    localparam int ADR_LINK_STS = 'h0C4;
    localparam int ADR_LANES    = 'h200;
    localparam int ADR_FRAME    = 'h210;
    localparam int ADR_PROC     = 'h214;
    localparam int ADR_MODE     = 'h240;
    localparam int ADR_MSYNC    = 'h248;
    localparam int ADR_ILAS     = 'h250;
    localparam int ADR_STATE    = 'h280;

    typedef enum logic { WR_IDLE, WR_RESP } wr_state_t;
    typedef enum logic { RD_IDLE, RD_DATA } rd_state_t;

    function automatic logic [31:0] strb_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [31:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/txlink_axil_port.sv
module txlink_axil_port
    import txlink_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [31:0]       rdata,
    output logic              wr_fire,
    output logic [WORD_W-1:0] wr_word,
    output logic [31:0]       wr_data,
    output logic [31:0]       wr_mask,
    output logic [WORD_W-1:0] rd_word,
    input  logic [31:0]       rd_data
);

    wr_state_t wr_q, wr_d;
    rd_state_t rd_q, rd_d;
    logic      rd_fire;
    logic [31:0] rdata_q;
    logic      unused_lsbs;

    assign unused_lsbs = ^{awaddr[1:0], araddr[1:0]};

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= WR_IDLE;
            rd_q <= RD_IDLE;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    // transitions
    always_comb begin
        wr_d = wr_q;
        unique case (wr_q)
            WR_IDLE: if (awvalid && wvalid) wr_d = WR_RESP;
            WR_RESP: if (bready)            wr_d = WR_IDLE;
        endcase
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: if (arvalid) rd_d = RD_DATA;
            RD_DATA: if (rready)  rd_d = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_fire = 1'b0;
        bvalid  = 1'b0;
        unique case (wr_q)
            WR_IDLE: wr_fire = awvalid && wvalid;
            WR_RESP: bvalid  = 1'b1;
        endcase
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (rd_q)
            RD_IDLE: arready = 1'b1;
            RD_DATA: rvalid  = 1'b1;
        endcase
    end

    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign rd_fire = arvalid && arready;
    assign wr_word = awaddr[ADDR_W-1:2];
    assign wr_data = wdata;
    assign wr_mask = strb_mask(wstrb);
    assign rd_word = araddr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_data;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/txlink_irq_unit.sv
module txlink_irq_unit #(
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] evt,
    input  logic               en_we,
    input  logic [NUM_IRQ-1:0] en_wdata,
    input  logic [NUM_IRQ-1:0] en_wmask,
    input  logic [NUM_IRQ-1:0] clr,
    output logic [NUM_IRQ-1:0] src,
    output logic [NUM_IRQ-1:0] en,
    output logic [NUM_IRQ-1:0] pending,
    output logic               irq
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        // an arriving event outranks a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)      src[i] <= 1'b0;
            else if (evt[i]) src[i] <= 1'b1;
            else if (clr[i]) src[i] <= 1'b0;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                    en[i] <= 1'b0;
            else if (en_we && en_wmask[i]) en[i] <= en_wdata[i];
        end
        assign pending[i] = src[i] & en[i];
    end

    assign irq = |pending;

endmodule

// File: rtl/txlink_cfg_bank.sv
module txlink_cfg_bank
    import txlink_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_LANES = 4,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_fire,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [31:0]          wr_data,
    input  logic [31:0]          wr_mask,
    input  logic                 ext_reset,
    output logic                 link_en,
    output logic                 link_off_q,
    output logic [31:0]          scratch_q,
    output logic                 sync_pulse,
    output logic [NUM_LANES-1:0] lanes_off,
    output logic [FR_W-1:0]      frame_oct,
    output logic [MF_W-1:0]      mf_oct,
    output logic                 scr_off,
    output logic                 repl_off,
    output logic [MODE_W-1:0]    mode,
    output logic [31:0]          ilas_word
);

    localparam logic [WORD_W-1:0] W_SCRATCH  = WORD_W'(ADR_SCRATCH / 4);
    localparam logic [WORD_W-1:0] W_LINK_OFF = WORD_W'(ADR_LINK_OFF / 4);
    localparam logic [WORD_W-1:0] W_LANES    = WORD_W'(ADR_LANES / 4);
    localparam logic [WORD_W-1:0] W_FRAME    = WORD_W'(ADR_FRAME / 4);
    localparam logic [WORD_W-1:0] W_PROC     = WORD_W'(ADR_PROC / 4);
    localparam logic [WORD_W-1:0] W_MODE     = WORD_W'(ADR_MODE / 4);
    localparam logic [WORD_W-1:0] W_MSYNC    = WORD_W'(ADR_MSYNC / 4);
    localparam logic [WORD_W-1:0] W_ILAS     = WORD_W'(ADR_ILAS / 4);
    localparam logic [MF_W-1:0]   MF_RESET   = MF_W'(31);

    logic cfg_we;

    assign link_en = !link_off_q && !ext_reset;
    assign cfg_we  = wr_fire && !link_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q  <= '0;
            link_off_q <= 1'b1;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= wr_fire && (wr_word == W_MSYNC) && wr_data[0]
                          && wr_mask[0] && link_en;
            if (wr_fire && wr_word == W_SCRATCH)
                scratch_q <= merge(scratch_q, wr_data, wr_mask);
            if (wr_fire && wr_word == W_LINK_OFF && wr_mask[0])
                link_off_q <= wr_data[0];
        end
    end

    // locked configuration: writable only while the link is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_off <= '0;
            frame_oct <= '0;
            mf_oct    <= MF_RESET;
            scr_off   <= 1'b0;
            repl_off  <= 1'b0;
            mode      <= '0;
            ilas_word <= '0;
        end else if (cfg_we) begin
            if (wr_word == W_LANES)
                lanes_off <= NUM_LANES'(merge(32'(lanes_off), wr_data, wr_mask));
            if (wr_word == W_FRAME) begin
                frame_oct <= FR_W'(merge(32'(frame_oct), wr_data, wr_mask));
                mf_oct    <= MF_W'(merge({6'd0, mf_oct, 16'd0}, wr_data, wr_mask) >> 16);
            end
            if (wr_word == W_PROC && wr_mask[0]) begin
                scr_off  <= wr_data[0];
                repl_off <= wr_data[1];
            end
            if (wr_word == W_MODE && wr_mask[0])
                mode <= wr_data[MODE_W-1:0];
            if (wr_word == W_ILAS)
                ilas_word <= merge(ilas_word, wr_data, wr_mask);
        end
    end

endmodule

// File: rtl/txlink_csr.sv
module txlink_csr
    import txlink_csr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_LANES = 4,
    parameter int          NUM_IRQ   = 5,
    parameter logic [31:0] VERSION   = 32'h0001_0200,
    parameter logic [31:0] INST_ID   = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [ADDR_W-1:0]    awaddr,
    input  logic                 wvalid,
    output logic                 wready,
    input  logic [31:0]          wdata,
    input  logic [3:0]           wstrb,
    output logic                 bvalid,
    input  logic                 bready,
    output logic [1:0]           bresp,
    input  logic                 arvalid,
    output logic                 arready,
    input  logic [ADDR_W-1:0]    araddr,
    output logic                 rvalid,
    input  logic                 rready,
    output logic [31:0]          rdata,
    output logic [1:0]           rresp,
    input  logic [NUM_IRQ-1:0]   irq_evt,
    input  logic                 ext_reset,
    input  logic                 link_init,
    input  logic [1:0]           link_state,
    output logic                 link_en,
    output logic                 sync_pulse,
    output logic                 irq,
    output logic [NUM_LANES-1:0] cfg_lanes_off,
    output logic [7:0]           cfg_frame_oct,
    output logic [9:0]           cfg_mf_oct,
    output logic                 cfg_scr_off,
    output logic                 cfg_repl_off,
    output logic [2:0]           cfg_mode,
    output logic [31:0]          cfg_ilas_word
);

    localparam int WORD_W = ADDR_W - 2;

    logic              wr_fire;
    logic [WORD_W-1:0] wr_word, rd_word;
    logic [31:0]       wr_data, wr_mask, rd_data;
    logic              link_off_q;
    logic [31:0]       scratch_q;
    logic [NUM_IRQ-1:0] irq_src, irq_en_q, irq_pend, irq_clr;
    logic              en_we;

    assign bresp = 2'b00;
    assign rresp = 2'b00;

    txlink_axil_port #(.ADDR_W(ADDR_W)) i_port (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .bvalid(bvalid), .bready(bready),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata),
        .wr_fire(wr_fire), .wr_word(wr_word), .wr_data(wr_data),
        .wr_mask(wr_mask), .rd_word(rd_word), .rd_data(rd_data)
    );

    txlink_cfg_bank #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_word(wr_word), .wr_data(wr_data),
        .wr_mask(wr_mask), .ext_reset(ext_reset),
        .link_en(link_en), .link_off_q(link_off_q), .scratch_q(scratch_q),
        .sync_pulse(sync_pulse), .lanes_off(cfg_lanes_off),
        .frame_oct(cfg_frame_oct), .mf_oct(cfg_mf_oct),
        .scr_off(cfg_scr_off), .repl_off(cfg_repl_off),
        .mode(cfg_mode), .ilas_word(cfg_ilas_word)
    );

    assign en_we   = wr_fire && (wr_word == WORD_W'(ADR_IRQ_EN / 4));
    assign irq_clr = (wr_fire && (wr_word == WORD_W'(ADR_IRQ_SRC / 4) ||
                                  wr_word == WORD_W'(ADR_IRQ_PEND / 4)))
                     ? (wr_data[NUM_IRQ-1:0] & wr_mask[NUM_IRQ-1:0]) : '0;

    txlink_irq_unit #(.NUM_IRQ(NUM_IRQ)) i_irq (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt),
        .en_we(en_we), .en_wdata(wr_data[NUM_IRQ-1:0]),
        .en_wmask(wr_mask[NUM_IRQ-1:0]), .clr(irq_clr),
        .src(irq_src), .en(irq_en_q), .pending(irq_pend), .irq(irq)
    );

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_word)
            WORD_W'(ADR_VERSION / 4):  rd_data = VERSION;
            WORD_W'(ADR_INST / 4):     rd_data = INST_ID;
            WORD_W'(ADR_SCRATCH / 4):  rd_data = scratch_q;
            WORD_W'(ADR_IDENT / 4):    rd_data = IDENT_WORD;
            WORD_W'(ADR_IRQ_EN / 4):   rd_data = 32'(irq_en_q);
            WORD_W'(ADR_IRQ_PEND / 4): rd_data = 32'(irq_pend);
            WORD_W'(ADR_IRQ_SRC / 4):  rd_data = 32'(irq_src);
            WORD_W'(ADR_LINK_OFF / 4): rd_data = {31'd0, link_off_q};
            WORD_W'(ADR_LINK_STS / 4): rd_data = {30'd0, ext_reset, !link_en || link_init};
            WORD_W'(ADR_LANES / 4):    rd_data = 32'(cfg_lanes_off);
            WORD_W'(ADR_FRAME / 4):    rd_data = {6'd0, cfg_mf_oct, 8'd0, cfg_frame_oct};
            WORD_W'(ADR_PROC / 4):     rd_data = {30'd0, cfg_repl_off, cfg_scr_off};
            WORD_W'(ADR_MODE / 4):     rd_data = {29'd0, cfg_mode};
            WORD_W'(ADR_ILAS / 4):     rd_data = cfg_ilas_word;
            WORD_W'(ADR_STATE / 4):    rd_data = {30'd0, link_state};
            default:                   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/txlink_csr_chk.sv
module txlink_csr_chk #(
    parameter int NUM_IRQ = 5,
    parameter int NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_IRQ-1:0]   irq_evt,
    input logic [NUM_IRQ-1:0]   irq_src,
    input logic                 link_en,
    input logic                 ext_reset,
    input logic                 sync_pulse,
    input logic [2:0]           cfg_mode,
    input logic [NUM_LANES-1:0] cfg_lanes_off,
    input logic                 bvalid,
    input logic                 bready,
    input logic                 rvalid,
    input logic                 rready
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_evt
        // R6 and R12: an event is recorded on the next edge, even against a clear
        assert_evt_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_evt[i] |=> irq_src[i]);
    end

    assert_sync_needs_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(link_en));

    assert_sync_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    assert_ext_reset_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset |-> !link_en);

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && $past(link_en)) |-> ($stable(cfg_mode) && $stable(cfg_lanes_off)));

    assert_bvalid_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    assert_rvalid_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);

endmodule

bind txlink_csr txlink_csr_chk #(.NUM_IRQ(NUM_IRQ), .NUM_LANES(NUM_LANES)) i_chk (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .irq_src(irq_src),
    .link_en(link_en), .ext_reset(ext_reset), .sync_pulse(sync_pulse),
    .cfg_mode(cfg_mode), .cfg_lanes_off(cfg_lanes_off),
    .bvalid(bvalid), .bready(bready), .rvalid(rvalid), .rready(rready)
);

// File: tb/test_txlink_csr.sv
module test_txlink_csr;

    localparam int ADDR_W = 12;
    localparam int LANES  = 6;
    localparam int NIRQ   = 5;
    localparam logic [31:0] VER = 32'h0001_0200;
    localparam logic [31:0] IID = 32'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic bready = 1'b1, rready = 1'b1;
    logic awready, wready, bvalid, arready, rvalid;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  wstrb = 4'hF;
    logic [1:0]  bresp, rresp;
    logic [NIRQ-1:0] irq_evt = '0;
    logic ext_reset = 1'b0, link_init = 1'b0;
    logic [1:0] link_state = 2'd0;
    logic link_en, sync_pulse, irq;
    logic [LANES-1:0] cfg_lanes_off;
    logic [7:0] cfg_frame_oct;
    logic [9:0] cfg_mf_oct;
    logic cfg_scr_off, cfg_repl_off;
    logic [2:0] cfg_mode;
    logic [31:0] cfg_ilas_word;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    txlink_csr #(.ADDR_W(ADDR_W), .NUM_LANES(LANES), .NUM_IRQ(NIRQ),
                 .VERSION(VER), .INST_ID(IID)) i_txlink_csr (.*);

    always @(negedge clk) if (sync_pulse) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pend(input logic [NIRQ-1:0] s, input logic [NIRQ-1:0] e);
        return 32'(s & e);
    endfunction

    task automatic wr(input int addr, input logic [31:0] d,
                      input logic [3:0] s = 4'hF, input logic [NIRQ-1:0] ev = '0);
        @(negedge clk);
        awaddr = ADDR_W'(addr); wdata = d; wstrb = s;
        awvalid = 1'b1; wvalid = 1'b1; irq_evt = ev;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; irq_evt = '0;
        while (!bvalid) @(negedge clk);
        chk("R11 bresp", 32'(bresp), 32'd0);
        @(posedge clk);
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        araddr = ADDR_W'(addr); arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        d = rdata;
        chk("R11 rresp", 32'(rresp), 32'd0);
        @(posedge clk);
    endtask

    task automatic pulse_evt(input logic [NIRQ-1:0] v);
        @(negedge clk); irq_evt = v;
        @(negedge clk); irq_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NIRQ-1:0] m_src, m_en;
        int p0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R3 link_en reset", 32'(link_en), 0);
        chk("R7 irq reset", 32'(irq), 0);
        rd('h0C4, d); chk("R4 status reset", d, 32'h1);
        rd('h008, d); chk("R2 scratch reset", d, 0);
        rd('h0C0, d); chk("R3 disable reset", d, 1);
        chk("R5 mf reset", 32'(cfg_mf_oct), 31);

        // identification
        rd('h000, d); chk("R1 version", d, VER);
        rd('h004, d); chk("R1 inst id", d, IID);
        rd('h00C, d); chk("R1 ident", d, 32'h3230_3454);
        wr('h00C, 32'hFFFF_FFFF); wr('h004, 32'h0); wr('h000, 32'h0);
        rd('h00C, d); chk("R1 ident after write", d, 32'h3230_3454);
        rd('h004, d); chk("R1 id after write", d, IID);
        rd('h000, d); chk("R1 version after write", d, VER);

        // scratch
        wr('h008, 32'hA5C3_0F96); rd('h008, d); chk("R2 scratch rw", d, 32'hA5C3_0F96);
        wr('h008, 32'h1122_3344, 4'b0010); rd('h008, d);
        chk("R2 scratch strobe", d, 32'hA5C3_3396);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v = $urandom;
            wr('h008, v); rd('h008, d); chk("R2 scratch random", d, v);
        end

        // configuration while disabled
        wr('h200, 32'hFFFF_FFE5); chk("R5 lanes", 32'(cfg_lanes_off), 32'h25);
        wr('h210, 32'h007F_0003);
        chk("R5 frame", 32'(cfg_frame_oct), 3); chk("R5 mf", 32'(cfg_mf_oct), 32'h7F);
        wr('h214, 32'h3); chk("R5 proc", {cfg_repl_off, cfg_scr_off}, 2'b11);
        wr('h240, 32'h5); chk("R5 mode", 32'(cfg_mode), 5);
        wr('h250, 32'hDEAD_BEEF); chk("R5 ilas", cfg_ilas_word, 32'hDEAD_BEEF);

        // manual sync while disabled
        p0 = pulses; wr('h248, 1); repeat (2) @(negedge clk);
        chk("R9 no pulse disabled", pulses - p0, 0);

        // enable
        wr('h0C0, 0); chk("R3 enabled", 32'(link_en), 1);
        rd('h0C4, d); chk("R4 status enabled", d, 0);
        link_init = 1'b1; rd('h0C4, d); chk("R4 status init", d, 1); link_init = 1'b0;

        // locked configuration
        wr('h240, 32'h2); chk("R5 mode locked", 32'(cfg_mode), 5);
        wr('h200, 32'h0); chk("R5 lanes locked", 32'(cfg_lanes_off), 32'h25);
        wr('h250, 32'h0); rd('h250, d); chk("R5 ilas locked", d, 32'hDEAD_BEEF);

        // manual sync enabled
        p0 = pulses; wr('h248, 1); repeat (2) @(negedge clk);
        chk("R9 one pulse", pulses - p0, 1);
        p0 = pulses; wr('h248, 0); repeat (2) @(negedge clk);
        chk("R9 zero write no pulse", pulses - p0, 0);
        rd('h248, d); chk("R9 reads zero", d, 0);

        // external reset
        @(negedge clk); ext_reset = 1'b1; @(negedge clk);
        chk("R4 ext reset forces off", 32'(link_en), 0);
        rd('h0C4, d); chk("R4 status ext reset", d, 3);
        @(negedge clk); ext_reset = 1'b0; @(negedge clk);
        chk("R4 ext reset released", 32'(link_en), 1);

        // state code and unmapped
        link_state = 2'd2; rd('h280, d); chk("R10 state", d, 2);
        link_state = 2'd3; rd('h280, d); chk("R10 state", d, 3);
        rd('h3F0, d); chk("R11 unmapped", d, 0);
        rd('h0FC, d); chk("R11 unmapped", d, 0);

        // disable again
        wr('h0C0, 1); chk("R3 disabled", 32'(link_en), 0);

        // interrupts
        pulse_evt(5'b00101); @(negedge clk);
        chk("R7 irq disabled", 32'(irq), 0);
        rd('h088, d); chk("R6 recorded", d, 32'h5);
        rd('h084, d); chk("R7 pending masked", d, 0);
        pulse_evt(5'b00100); rd('h088, d); chk("R6 sticky", d, 32'h5);
        wr('h080, 32'h4); chk("R7 irq enable", 32'(irq), 1);
        rd('h084, d); chk("R7 pending", d, 32'h4);
        wr('h084, 32'h4); chk("R8 clear via pending", 32'(irq), 0);
        rd('h088, d); chk("R8 after pending clear", d, 32'h1);
        pulse_evt(5'b11010);
        wr('h088, 32'h1B); rd('h088, d); chk("R8 multi clear", d, 0);
        wr('h088, 32'h1, 4'hF, 5'b00001); rd('h088, d); chk("R12 event wins", d, 32'h1);
        wr('h088, 32'h1); rd('h088, d); chk("R8 clear single", d, 0);

        // random interrupt traffic
        m_src = '0; m_en = 5'b00100;
        for (int k = 0; k < 150; k++) begin
            logic [NIRQ-1:0] v = NIRQ'($urandom);
            logic [31:0] w = $urandom;
            pulse_evt(v); m_src |= v;
            case ($urandom % 3)
                0: begin wr('h080, w); m_en = w[NIRQ-1:0]; end
                1: begin wr('h088, w); m_src &= ~w[NIRQ-1:0]; end
                default: begin wr('h084, w); m_src &= ~w[NIRQ-1:0]; end
            endcase
            rd('h084, d); chk("R7 random pending", d, exp_pend(m_src, m_en));
            rd('h088, d); chk("R6 random source", d, 32'(m_src));
            chk("R7 random irq", 32'(irq), 32'(|(m_src & m_en)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule